// File: doc/BRIEF.md
# Snoop-Driven Cache Line Invalidator

This block keeps a two-way set-associative read cache coherent when another bus master writes to shared memory. The cache keeps its tags and data in dual-port RAMs. Way 0 uses port A and way 1 uses port B.

Each snoop strobe carries the word address of a foreign write. The block takes that address in at once and never pushes back on the writer. It keeps the address in a one-entry pending slot. It then asks the CPU-side controller for the RAM ports and waits for a grant. Once granted, it reads the tag of each way at the snooped set and compares both. For every way whose tag matches, it clears the valid bits of all four words of the line.

The CPU-side controller has priority for the ports. The invalidator only holds a request line high. After a grant, it finishes its whole sequence without a break.

Top module: `snoop_invalidator`

## Requirements
- R1: The block samples `snoop_req_i` on every rising edge and has no stall output. A high strobe stores `snoop_addr_i` in the pending slot at that edge. A later strobe that finds the slot still full replaces the older address.
- R2: A strobe that arrives while the slot is full, and the slot is not being emptied on the same edge, raises `ovf_o` for exactly one cycle after that edge.
- R3: `req_o` rises in the cycle after an idle block takes a pending entry. It stays high until the sequence ends. No data write happens in the first cycle of a request.
- R4: `gnt_i` is examined only while the request waits. After it is seen, the tag read, the compare and any clears run back to back whatever `gnt_i` does.
- R5: In the cycle after the grant, the tag addresses are `{1'b0,set}` on port A and `{1'b1,set}` on port B, where set = address bits 10:3. Tag read data is compared one cycle later.
- R6: A way matches when bits 16:0 of its tag word equal address bits 20:11 zero-extended to 17 bits. Bit 17 of the tag word (the recency flag) is ignored. A stored tag with any bit above bit 9 set never matches.
- R7: For a matching way, the block clears the line in four consecutive cycles. It writes words `{way,set,0}` to `{way,set,3}` in ascending order, with `data_wdata_o` all zero, so byte-lane valid bits 17:16 become 0.
- R8: When both ways match, both write enables are asserted in the same four cycles. Both lines end up invalid.
- R9: When neither way matches, no data write occurs. `req_o` falls after the compare cycle. All data words stay as they were.
- R10: While `rst_ni` is low, `req_o`, `ovf_o` and both write enables are 0, and the pending slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snoop_req_i | input | 1 | One-cycle strobe per foreign write |
| snoop_addr_i | input | 21 | Word address of the foreign write |
| ovf_o | output | 1 | Pending-slot overwrite pulse |
| req_o | output | 1 | Request for the cache RAM ports |
| gnt_i | input | 1 | Port grant from the CPU-side controller |
| tag_addr_a_o | output | 9 | Tag RAM port A address (way 0) |
| tag_addr_b_o | output | 9 | Tag RAM port B address (way 1) |
| tag_rdata_a_i | input | 18 | Tag RAM port A read data |
| tag_rdata_b_i | input | 18 | Tag RAM port B read data |
| data_addr_a_o | output | 11 | Data RAM port A address (way 0) |
| data_addr_b_o | output | 11 | Data RAM port B address (way 1) |
| data_we_a_o | output | 1 | Data RAM port A write enable |
| data_we_b_o | output | 1 | Data RAM port B write enable |
| data_wdata_o | output | 18 | Data RAM write word, shared by both ports |

## Verification
A wrong sequencer state shows at the ports in the same cycle. `req_o` or a write enable will differ from the reference for a cycle, or a clear will land on a word out of order. A wrong match result or a corrupted pending address shows up later. It appears as a line that should have been cleared but still holds set valid bits, or a foreign line that was wiped. Either kind of error is caught by the full comparison of the RAM image at the end of the run. A stale pending flag shows as a spurious or missing `ovf_o` pulse one edge after the strobe.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_LOOK,
    ST_CMP,
    ST_CLR
  } seq_st_e;
endpackage

// File: rtl/snp_capture.sv
module snp_capture #(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snoop_req_i,
  input  logic [AW-1:0] snoop_addr_i,
  input  logic          take_i,
  output logic          pend_v_o,
  output logic [AW-1:0] pend_addr_o,
  output logic          ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_o    <= 1'b0;
      pend_addr_o <= '0;
      ovf_o       <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (snoop_req_i) begin
        // writer is never held off: newest address always wins the slot
        pend_addr_o <= snoop_addr_i;
        pend_v_o    <= 1'b1;
        ovf_o       <= pend_v_o & ~take_i;
      end else if (take_i) begin
        pend_v_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/snp_match.sv
module snp_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 17,
  parameter int KEY_W = 10
) (
  input  logic [WAYS*(TAG_W+1)-1:0] tag_rd_i,
  input  logic [KEY_W-1:0]          key_i,
  output logic [WAYS-1:0]           hit_o
);
  localparam int TW  = TAG_W + 1;
  localparam int PAD = TAG_W - KEY_W;

  logic [TAG_W-1:0] key_ext;
  assign key_ext = {{PAD{1'b0}}, key_i};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TW-1:0] word;
    logic          unused_mru;
    assign word       = tag_rd_i[w*TW +: TW];
    assign unused_mru = word[TAG_W];
    assign hit_o[w]   = (word[TAG_W-1:0] == key_ext);
  end
endmodule

// File: rtl/snp_seq.sv
module snp_seq
  import snp_pkg::*;
#(
  parameter int JW     = 18,
  parameter int WSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_v_i,
  input  logic [JW-1:0]     pend_addr_i,
  input  logic              gnt_i,
  input  logic [1:0]        hit_i,
  output logic              take_o,
  output logic [JW-1:0]     job_o,
  output logic              req_o,
  output logic [1:0]        clr_we_o,
  output logic [WSEL_W-1:0] word_o
);
  seq_st_e    st_q;
  logic [1:0] hit_q;

  assign take_o   = (st_q == ST_IDLE) && pend_v_i;
  assign req_o    = (st_q != ST_IDLE);
  assign clr_we_o = {2{st_q == ST_CLR}} & hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      job_o  <= '0;
      hit_q  <= '0;
      word_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pend_v_i) begin
          job_o <= pend_addr_i;
          st_q  <= ST_REQ;
        end
        ST_REQ:  if (gnt_i) st_q <= ST_LOOK;
        ST_LOOK: st_q <= ST_CMP;  // tag RAM read latency
        ST_CMP: begin
          hit_q  <= hit_i;
          word_o <= '0;
          st_q   <= (|hit_i) ? ST_CLR : ST_IDLE;
        end
        ST_CLR: begin
          word_o <= word_o + 1'b1;
          if (word_o == '1) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_invalidator.sv
module snoop_invalidator #(
  parameter int SNP_AW = 21,
  parameter int SET_W  = 8,
  parameter int WSEL_W = 2,
  parameter int TAG_W  = 17,
  parameter int WORD_W = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                snoop_req_i,
  input  logic [SNP_AW-1:0]                   snoop_addr_i,
  output logic                                ovf_o,
  output logic                                req_o,
  input  logic                                gnt_i,
  output logic [SET_W:0]                      tag_addr_a_o,
  output logic [SET_W:0]                      tag_addr_b_o,
  input  logic [TAG_W:0]                      tag_rdata_a_i,
  input  logic [TAG_W:0]                      tag_rdata_b_i,
  output logic [SET_W+WSEL_W:0]               data_addr_a_o,
  output logic [SET_W+WSEL_W:0]               data_addr_b_o,
  output logic                                data_we_a_o,
  output logic                                data_we_b_o,
  output logic [WORD_W+1:0]                   data_wdata_o
);
  localparam int IDX_LSB = 1 + WSEL_W;
  localparam int TAG_LSB = IDX_LSB + SET_W;
  localparam int KEY_W   = SNP_AW - TAG_LSB;
  localparam int JW      = SNP_AW - IDX_LSB;

  logic [IDX_LSB-1:0] unused_word_bits;
  assign unused_word_bits = snoop_addr_i[IDX_LSB-1:0];

  logic              pend_v, take;
  logic [JW-1:0]     pend_addr, job;
  logic [1:0]        hit, clr_we;
  logic [WSEL_W-1:0] word;
  logic [SET_W-1:0]  set_idx;
  logic [KEY_W-1:0]  key;

  snp_capture #(.AW(JW)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snoop_req_i (snoop_req_i),
    .snoop_addr_i(snoop_addr_i[SNP_AW-1:IDX_LSB]),
    .take_i      (take),
    .pend_v_o    (pend_v),
    .pend_addr_o (pend_addr),
    .ovf_o       (ovf_o)
  );

  assign set_idx = job[SET_W-1:0];
  assign key     = job[JW-1:SET_W];

  snp_match #(.WAYS(2), .TAG_W(TAG_W), .KEY_W(KEY_W)) u_match (
    .tag_rd_i({tag_rdata_b_i, tag_rdata_a_i}),
    .key_i   (key),
    .hit_o   (hit)
  );

  snp_seq #(.JW(JW), .WSEL_W(WSEL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_v_i   (pend_v),
    .pend_addr_i(pend_addr),
    .gnt_i      (gnt_i),
    .hit_i      (hit),
    .take_o     (take),
    .job_o      (job),
    .req_o      (req_o),
    .clr_we_o   (clr_we),
    .word_o     (word)
  );

  assign tag_addr_a_o  = {1'b0, set_idx};
  assign tag_addr_b_o  = {1'b1, set_idx};
  assign data_addr_a_o = {1'b0, set_idx, word};
  assign data_addr_b_o = {1'b1, set_idx, word};
  assign data_we_a_o   = clr_we[0];
  assign data_we_b_o   = clr_we[1];
  assign data_wdata_o  = '0;  // both lane-valid bits and payload cleared
endmodule

// File: rtl/snp_inv_chk.sv
module snp_inv_chk #(
  parameter int DAW = 11
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           snoop_req_i,
  input logic           ovf_o,
  input logic           req_o,
  input logic [DAW-1:0] data_addr_a_o,
  input logic [DAW-1:0] data_addr_b_o,
  input logic           data_we_a_o,
  input logic           data_we_b_o
);
  // R7
  we_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_a_o || data_we_b_o) |-> req_o);
  // R2
  ovf_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(snoop_req_i));
  // R3
  no_write_on_req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !$past(req_o)) |-> !(data_we_a_o || data_we_b_o));
  // R7
  clr_start_word0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_a_o && !$past(data_we_a_o)) |-> (data_addr_a_o[1:0] == 2'd0));
  // R7
  clr_ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_b_o && $past(data_we_b_o)) |->
      (data_addr_b_o[1:0] == $past(data_addr_b_o[1:0]) + 2'd1));
  // R2
  ovf_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !$past(snoop_req_i, 2)) |=> !ovf_o);
endmodule

bind snoop_invalidator snp_inv_chk #(.DAW(SET_W + WSEL_W + 1)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .snoop_req_i  (snoop_req_i),
  .ovf_o        (ovf_o),
  .req_o        (req_o),
  .data_addr_a_o(data_addr_a_o),
  .data_addr_b_o(data_addr_b_o),
  .data_we_a_o  (data_we_a_o),
  .data_we_b_o  (data_we_b_o)
);

// File: tb/sim_snoop_invalidator.sv
module sim_snoop_invalidator;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        snoop_req = 1'b0, gnt = 1'b0;
  logic [20:0] snoop_addr = '0;
  logic        ovf, req, we_a, we_b;
  logic [8:0]  ta_a, ta_b;
  logic [17:0] tr_a = '0, tr_b = '0, wdata;
  logic [10:0] da_a, da_b;

  snoop_invalidator u0 (
    .clk_i(clk), .rst_ni(rst_n), .snoop_req_i(snoop_req), .snoop_addr_i(snoop_addr),
    .ovf_o(ovf), .req_o(req), .gnt_i(gnt),
    .tag_addr_a_o(ta_a), .tag_addr_b_o(ta_b), .tag_rdata_a_i(tr_a), .tag_rdata_b_i(tr_b),
    .data_addr_a_o(da_a), .data_addr_b_o(da_b), .data_we_a_o(we_a), .data_we_b_o(we_b),
    .data_wdata_o(wdata)
  );

  logic [17:0] tag_mem  [512];
  logic [17:0] data_mem [2048];
  logic [17:0] exp_mem  [2048];

  always @(posedge clk) begin
    tr_a <= tag_mem[ta_a];
    tr_b <= tag_mem[ta_b];
    if (we_a) data_mem[da_a] <= wdata;
    if (we_b) data_mem[da_b] <= wdata;
  end

  int n_cmp = 0, n_bad = 0, ovf_cnt = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // behavioural reference
  int          m_st = 0, m_w = 0;
  bit          pv = 0, h0 = 0, h1 = 0, m_ovf = 0;
  logic [20:0] pa = '0, job = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_w = 0; pv = 0; h0 = 0; h1 = 0; m_ovf = 0;
    end else begin
      bit take;
      take  = (m_st == 0) && pv;
      m_ovf = snoop_req && pv && !take;
      case (m_st)
        0: if (pv) begin job = pa; m_st = 1; end
        1: if (gnt) m_st = 2;
        2: m_st = 3;
        3: begin
          h0 = tag_mem[{1'b0, job[10:3]}][16:0] == {7'b0, job[20:11]};
          h1 = tag_mem[{1'b1, job[10:3]}][16:0] == {7'b0, job[20:11]};
          for (int k = 0; k < 4; k++) begin
            if (h0) exp_mem[{1'b0, job[10:3], k[1:0]}] = '0;
            if (h1) exp_mem[{1'b1, job[10:3], k[1:0]}] = '0;
          end
          m_w  = 0;
          m_st = (h0 || h1) ? 4 : 0;
        end
        default: begin
          if (m_w == 3) m_st = 0;
          m_w++;
        end
      endcase
      if (snoop_req) begin pa = snoop_addr; pv = 1; end
      else if (take) pv = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ovf) ovf_cnt++;
      chk(req == (m_st != 0), "R3 req", req, m_st != 0);
      chk(ovf == m_ovf, "R2 ovf", ovf, m_ovf);
      chk(we_a == (m_st == 4 && h0), "R7 we_a", we_a, m_st == 4 && h0);
      chk(we_b == (m_st == 4 && h1), "R8 we_b", we_b, m_st == 4 && h1);
      if (we_a) chk(da_a == {1'b0, job[10:3], m_w[1:0]}, "R7 addr_a", da_a, {1'b0, job[10:3], m_w[1:0]});
      if (we_b) chk(da_b == {1'b1, job[10:3], m_w[1:0]}, "R7 addr_b", da_b, {1'b1, job[10:3], m_w[1:0]});
      if (we_a || we_b) chk(wdata == 18'h0, "R7 wdata", wdata, 0);
      if (m_st == 2) begin
        chk(ta_a == {1'b0, job[10:3]}, "R5 tag_a", ta_a, {1'b0, job[10:3]});
        chk(ta_b == {1'b1, job[10:3]}, "R5 tag_b", ta_b, {1'b1, job[10:3]});
      end
      gnt <= req && ($urandom_range(2) == 0);  // R4 grant may drop after acceptance
    end
  end

  function automatic logic [20:0] mk(input logic [7:0] idx, input logic [9:0] key);
    return {key, idx, 2'b01, 1'b0};
  endfunction

  task automatic snoop(input logic [20:0] a);
    @(negedge clk); snoop_req = 1'b1; snoop_addr = a;
    @(negedge clk); snoop_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int bad_words;
    for (int i = 0; i < 512; i++) tag_mem[i] = 18'h3FFFF;
    for (int i = 0; i < 2048; i++) begin
      data_mem[i] = {2'b11, i[15:0] ^ 16'h5A5A};
      exp_mem[i]  = data_mem[i];
    end
    tag_mem[{1'b0, 8'd5}]  = {1'b1, 7'h0, 10'h155};  // double match
    tag_mem[{1'b1, 8'd5}]  = {1'b0, 7'h0, 10'h155};
    tag_mem[{1'b0, 8'd9}]  = {1'b1, 7'h0, 10'h2AA};  // recency flag set
    tag_mem[{1'b1, 8'd9}]  = {1'b0, 7'h0, 10'h2AB};
    tag_mem[{1'b0, 8'd20}] = {1'b0, 7'h0, 10'h111};
    tag_mem[{1'b1, 8'd20}] = {1'b0, 7'h0, 10'h0F0};
    tag_mem[{1'b0, 8'd30}] = {1'b0, 7'h01, 10'h0C3}; // upper tag bit set
    tag_mem[{1'b0, 8'd50}] = {1'b0, 7'h0, 10'h003};
    tag_mem[{1'b0, 8'd51}] = {1'b0, 7'h0, 10'h004};
    tag_mem[{1'b1, 8'd52}] = {1'b0, 7'h0, 10'h005};

    repeat (3) @(negedge clk);
    // R10
    chk(req == 0, "R10 req", req, 0);
    chk(ovf == 0, "R10 ovf", ovf, 0);
    chk({we_a, we_b} == 0, "R10 we", {we_a, we_b}, 0);
    rst_n = 1'b1;

    snoop(mk(8'd5, 10'h155));  repeat (40) @(negedge clk);
    snoop(mk(8'd9, 10'h2AA));  repeat (40) @(negedge clk);
    snoop(mk(8'd20, 10'h0F0)); repeat (40) @(negedge clk);
    snoop(mk(8'd30, 10'h0C3)); repeat (40) @(negedge clk);

    // R1 R2: three strobes back to back, middle one overwritten
    @(negedge clk); snoop_req = 1'b1; snoop_addr = mk(8'd50, 10'h003);
    @(negedge clk); snoop_addr = mk(8'd51, 10'h004);
    @(negedge clk); snoop_addr = mk(8'd52, 10'h005);
    @(negedge clk); snoop_req = 1'b0;
    repeat (60) @(negedge clk);
    chk(ovf_cnt == 1, "R2 ovf pulses", ovf_cnt, 1);

    bad_words = 0;
    for (int i = 0; i < 2048; i++) if (data_mem[i] !== exp_mem[i]) bad_words++;
    chk(bad_words == 0, "R7 ram image", bad_words, 0);
    chk(data_mem[{1'b1, 8'd5, 2'd2}][17:16] == 2'b00, "R8 way1 set5", data_mem[{1'b1, 8'd5, 2'd2}], 0);
    chk(data_mem[{1'b0, 8'd5, 2'd3}][17:16] == 2'b00, "R8 way0 set5", data_mem[{1'b0, 8'd5, 2'd3}], 0);
    chk(data_mem[{1'b0, 8'd9, 2'd0}][17:16] == 2'b00, "R6 mru ignored", data_mem[{1'b0, 8'd9, 2'd0}], 0);
    chk(data_mem[{1'b1, 8'd9, 2'd1}][17:16] == 2'b11, "R6 way1 kept", data_mem[{1'b1, 8'd9, 2'd1}], 3);
    chk(data_mem[{1'b0, 8'd30, 2'd0}][17:16] == 2'b11, "R9 no match", data_mem[{1'b0, 8'd30, 2'd0}], 3);
    chk(data_mem[{1'b0, 8'd51, 2'd0}][17:16] == 2'b11, "R1 overwritten", data_mem[{1'b0, 8'd51, 2'd0}], 3);
    chk(data_mem[{1'b1, 8'd52, 2'd3}][17:16] == 2'b00, "R1 newest kept", data_mem[{1'b1, 8'd52, 2'd3}], 0);
    chk(data_mem[{1'b0, 8'd50, 2'd1}][17:16] == 2'b00, "R4 first job", data_mem[{1'b0, 8'd50, 2'd1}], 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule